// File: doc/BRIEF.md
# RV32 Instruction Predecoder and Packer

The block takes one 32-bit RV32IMA instruction word, together with a valid strobe, and returns a 54-bit predecoded entry one clock later. The entry holds four things. The first is a signed 7-bit operation identifier that names the exact operation. The second is the three register indices. The third is a 32-bit immediate that is already sign-extended or zero-extended. Because everything is resolved here, a later execution stage needs no further decoding. The entry can be written into an instruction store so that each fetch returns a ready-to-run record.

The block recognises the base integer, multiply/divide, atomic, CSR, fence and privileged groups, plus two custom system operations. Any encoding it does not recognise produces the illegal-instruction identifier with every other field cleared. The block does not execute operations, and it does not check whether a CSR access is permitted.

Top module: `predec_packer`

## Requirements
- R1: `outValid` equals `inValid` delayed by one clock. `outEntry` loads only in a cycle where `inValid` is high, and otherwise holds its last value.
- R2: The entry layout is: operation identifier in [53:47] (two's complement), rs2 in [46:42], rs1 in [41:37], rd in [36:32], immediate in [31:0]. After reset, `outEntry` is all zero and `outValid` is low.
- R3: Branch instructions (opcode 1100011) take these identifiers by funct3: 000 → -64, 001 → -63, 100 → -60, 101 → -59, 110 → -58, 111 → -57. The immediate is the sign-extended B offset. rs1 and rs2 are filled and rd is zero. The funct3 values 010 and 011 are illegal.
- R4: Loads (opcode 0000011) take these identifiers by funct3: 000 → -56, 001 → -55, 010 → -54, 100 → -52, 101 → -51. They carry the I immediate, rs1 and rd. Stores (opcode 0100011) take these identifiers by funct3: 000 → -50, 001 → -49, 010 → -48. They carry the S immediate, rs1 and rs2.
- R5: LUI (0110111) is -53 and AUIPC (0010111) is -8; both carry the U immediate (upper 20 bits, low 12 zero) and rd. JAL (1101111) is -62 and carries the J offset and rd. JALR (1100111, funct3 000) is -61 and carries the I immediate, rs1 and rd.
- R6: Register-immediate instructions (0010011) take these identifiers by funct3: ADDI 000 → -36, SLTI 010 → -34, SLTIU 011 → -33, XORI 100 → -32, ORI 110 → -30, ANDI 111 → -29. Shifts take SLLI → -3, SRLI → -2, SRAI (bit 30 set) → -1; their immediate is the 5-bit shift amount, zero-extended. A shift with any other upper bits is illegal.
- R7: Register-register instructions (0110011) have a zero immediate and carry rs1, rs2 and rd. With funct7 0000000, funct3 0..7 maps to -28, -27, -26, -25, -24, -23, -22, -21. With funct7 0100000, funct3 000 is -35 and 101 is -31. With funct7 0000001, funct3 0..7 maps to -20 through -13. Every other funct7 is illegal.
- R8: Atomics (0101111, funct3 010) are selected by bits [31:27], and the ordering bits [26:25] are ignored. The mapping is 00000 → -47, 00001 → -46, 00010 → -45, 00011 → -44, 00100 → -43, 01000 → -42, 01100 → -41, 10000 → -40, 10100 → -39, 11000 → -38, 11100 → -37. The immediate is zero. The -45 form (load-reserved) requires rs2 = 0 and outputs a zero rs2 field.
- R9: CSR instructions (1110011) take these identifiers by funct3: 001 → -11, 010 → -10, 011 → -9, 101 → -7, 110 → -6, 111 → -5. The immediate is the 12-bit CSR address, zero-extended. The rs1 field carries bits [19:15], and rd is filled.
- R10: SYSTEM funct3 000 with rs1 = rd = 0 and bits [31:20] equal to 0x000, 0x001, 0x302 or 0x105 gives -12, with those 12 bits as the immediate. Any other such word is illegal. FENCE (0001111, funct3 000) gives -4 with the sign-extended I immediate and zero register fields.
- R11: The custom opcode (default 0001011) gives identifier 1 for funct3 000 and identifier 2 for funct3 001. Both carry the I immediate, rs1 and rd. Other funct3 values are illegal.
- R12: Any unrecognised word, including one whose bits [1:0] are not 11, gives an entry that is entirely zero (identifier 0).
- R13: Register fields that the decoded format does not use are output as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction word is valid this cycle |
| inInst | input | 32 | Raw instruction word |
| outValid | output | 1 | Packed entry is valid |
| outEntry | output | 54 | Packed predecoded entry |

## Verification
Two things can happen in the same cycle: a new word is captured while the packed result of the previous word is being presented. The bench provokes this by holding `inValid` high across back-to-back words of different groups. After every edge it judges that the entry shown belongs to the word driven one cycle earlier. The opposite case is a cycle with `inValid` low and a changed word on the input. It is judged by seeing `outValid` drop while the entry still holds the previous result.

// File: rtl/predec_pkg.sv
package predec_pkg;

  localparam int XLEN     = 32;
  localparam int REG_W    = 5;
  localparam int OP_W     = 7;
  localparam int ENTRY_W  = OP_W + 3 * REG_W + XLEN;
  localparam int RS2_LSB  = XLEN + 2 * REG_W;
  localparam int RS1_LSB  = XLEN + REG_W;
  localparam int RD_LSB   = XLEN;
  localparam int OP_LSB   = XLEN + 3 * REG_W;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_AMO    = 7'b0101111;
  localparam logic [6:0] OPC_FENCE  = 7'b0001111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  // Operation identifiers, two's complement in OP_W bits
  typedef enum logic [OP_W-1:0] {
    OP_ILLEGAL = 7'd0,   OP_CUSTA  = 7'd1,   OP_CUSTB  = 7'd2,
    OP_BEQ     = 7'd64,  OP_BNE    = 7'd65,  OP_JAL    = 7'd66,  OP_JALR  = 7'd67,
    OP_BLT     = 7'd68,  OP_BGE    = 7'd69,  OP_BLTU   = 7'd70,  OP_BGEU  = 7'd71,
    OP_LB      = 7'd72,  OP_LH     = 7'd73,  OP_LW     = 7'd74,  OP_LUI   = 7'd75,
    OP_LBU     = 7'd76,  OP_LHU    = 7'd77,  OP_SB     = 7'd78,  OP_SH    = 7'd79,
    OP_SW      = 7'd80,  OP_AADD   = 7'd81,  OP_ASWAP  = 7'd82,  OP_LRES  = 7'd83,
    OP_SCOND   = 7'd84,  OP_AXOR   = 7'd85,  OP_AOR    = 7'd86,  OP_AAND  = 7'd87,
    OP_AMIN    = 7'd88,  OP_AMAX   = 7'd89,  OP_AMINU  = 7'd90,  OP_AMAXU = 7'd91,
    OP_ADDI    = 7'd92,  OP_SUB    = 7'd93,  OP_SLTI   = 7'd94,  OP_SLTIU = 7'd95,
    OP_XORI    = 7'd96,  OP_SRA    = 7'd97,  OP_ORI    = 7'd98,  OP_ANDI  = 7'd99,
    OP_ADD     = 7'd100, OP_SLL    = 7'd101, OP_SLT    = 7'd102, OP_SLTU  = 7'd103,
    OP_XOR     = 7'd104, OP_SRL    = 7'd105, OP_OR     = 7'd106, OP_AND   = 7'd107,
    OP_MUL     = 7'd108, OP_MULH   = 7'd109, OP_MULHSU = 7'd110, OP_MULHU = 7'd111,
    OP_DIV     = 7'd112, OP_DIVU   = 7'd113, OP_REM    = 7'd114, OP_REMU  = 7'd115,
    OP_PRIV    = 7'd116, OP_CSRRW  = 7'd117, OP_CSRRS  = 7'd118, OP_CSRRC = 7'd119,
    OP_AUIPC   = 7'd120, OP_CSRRWI = 7'd121, OP_CSRRSI = 7'd122, OP_CSRRCI = 7'd123,
    OP_FENCE   = 7'd124, OP_SLLI   = 7'd125, OP_SRLI   = 7'd126, OP_SRAI  = 7'd127
  } opId_e;

  typedef enum logic [2:0] {
    IMM_ZERO, IMM_I, IMM_S, IMM_B, IMM_U, IMM_J, IMM_SYS, IMM_SHAMT
  } immSel_e;

  typedef struct packed {
    logic    load;
    opId_e   opId;
    immSel_e immSel;
    logic    useRs1;
    logic    useRs2;
    logic    useRd;
  } decStrobes_t;

endpackage

// File: rtl/predec_ctrl.sv
module predec_ctrl
  import predec_pkg::*;
#(
  parameter logic [6:0] CUSTOM_OPCODE = 7'b0001011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [XLEN-1:0]   inst,
  output decStrobes_t       strobes,
  output logic              outValid
);

  logic [6:0]  opcode;
  logic [2:0]  funct3;
  logic [6:0]  funct7;
  logic [11:0] funct12;
  logic [4:0]  funct5;
  logic        rs1Zero, rs2Zero, rdZero;
  decStrobes_t dec;

  assign opcode  = inst[6:0];
  assign funct3  = inst[14:12];
  assign funct7  = inst[31:25];
  assign funct12 = inst[31:20];
  assign funct5  = inst[31:27];
  assign rs1Zero = (inst[19:15] == '0);
  assign rs2Zero = (inst[24:20] == '0);
  assign rdZero  = (inst[11:7] == '0);

  function automatic decStrobes_t mk(opId_e o, immSel_e s, logic a, logic b, logic d);
    decStrobes_t r;
    r.load   = 1'b0;
    r.opId   = o;
    r.immSel = s;
    r.useRs1 = a;
    r.useRs2 = b;
    r.useRd  = d;
    return r;
  endfunction

  always_comb begin
    opId_e tmp;
    tmp = OP_ILLEGAL;
    dec = mk(OP_ILLEGAL, IMM_ZERO, 1'b0, 1'b0, 1'b0);
    if (inst[1:0] == 2'b11) begin
      if (opcode == CUSTOM_OPCODE) begin
        if (funct3 == 3'b000)      dec = mk(OP_CUSTA, IMM_I, 1'b1, 1'b0, 1'b1);
        else if (funct3 == 3'b001) dec = mk(OP_CUSTB, IMM_I, 1'b1, 1'b0, 1'b1);
      end else begin
        case (opcode)
          OPC_LUI:   dec = mk(OP_LUI, IMM_U, 1'b0, 1'b0, 1'b1);
          OPC_AUIPC: dec = mk(OP_AUIPC, IMM_U, 1'b0, 1'b0, 1'b1);
          OPC_JAL:   dec = mk(OP_JAL, IMM_J, 1'b0, 1'b0, 1'b1);
          OPC_JALR:  if (funct3 == 3'b000) dec = mk(OP_JALR, IMM_I, 1'b1, 1'b0, 1'b1);
          OPC_BRANCH: begin
            case (funct3)
              3'b000: tmp = OP_BEQ;
              3'b001: tmp = OP_BNE;
              3'b100: tmp = OP_BLT;
              3'b101: tmp = OP_BGE;
              3'b110: tmp = OP_BLTU;
              3'b111: tmp = OP_BGEU;
              default: tmp = OP_ILLEGAL;
            endcase
            if (tmp != OP_ILLEGAL) dec = mk(tmp, IMM_B, 1'b1, 1'b1, 1'b0);
          end
          OPC_LOAD: begin
            case (funct3)
              3'b000: tmp = OP_LB;
              3'b001: tmp = OP_LH;
              3'b010: tmp = OP_LW;
              3'b100: tmp = OP_LBU;
              3'b101: tmp = OP_LHU;
              default: tmp = OP_ILLEGAL;
            endcase
            if (tmp != OP_ILLEGAL) dec = mk(tmp, IMM_I, 1'b1, 1'b0, 1'b1);
          end
          OPC_STORE: begin
            case (funct3)
              3'b000: tmp = OP_SB;
              3'b001: tmp = OP_SH;
              3'b010: tmp = OP_SW;
              default: tmp = OP_ILLEGAL;
            endcase
            if (tmp != OP_ILLEGAL) dec = mk(tmp, IMM_S, 1'b1, 1'b1, 1'b0);
          end
          OPC_OPIMM: begin
            case (funct3)
              3'b000: dec = mk(OP_ADDI, IMM_I, 1'b1, 1'b0, 1'b1);
              3'b010: dec = mk(OP_SLTI, IMM_I, 1'b1, 1'b0, 1'b1);
              3'b011: dec = mk(OP_SLTIU, IMM_I, 1'b1, 1'b0, 1'b1);
              3'b100: dec = mk(OP_XORI, IMM_I, 1'b1, 1'b0, 1'b1);
              3'b110: dec = mk(OP_ORI, IMM_I, 1'b1, 1'b0, 1'b1);
              3'b111: dec = mk(OP_ANDI, IMM_I, 1'b1, 1'b0, 1'b1);
              3'b001: if (funct7 == 7'b0000000) dec = mk(OP_SLLI, IMM_SHAMT, 1'b1, 1'b0, 1'b1);
              default: begin
                if (funct7 == 7'b0000000)      dec = mk(OP_SRLI, IMM_SHAMT, 1'b1, 1'b0, 1'b1);
                else if (funct7 == 7'b0100000) dec = mk(OP_SRAI, IMM_SHAMT, 1'b1, 1'b0, 1'b1);
              end
            endcase
          end
          OPC_OP: begin
            case (funct7)
              7'b0000000: begin
                case (funct3)
                  3'd0: tmp = OP_ADD;
                  3'd1: tmp = OP_SLL;
                  3'd2: tmp = OP_SLT;
                  3'd3: tmp = OP_SLTU;
                  3'd4: tmp = OP_XOR;
                  3'd5: tmp = OP_SRL;
                  3'd6: tmp = OP_OR;
                  default: tmp = OP_AND;
                endcase
              end
              7'b0100000: begin
                if (funct3 == 3'd0)      tmp = OP_SUB;
                else if (funct3 == 3'd5) tmp = OP_SRA;
              end
              7'b0000001: begin
                case (funct3)
                  3'd0: tmp = OP_MUL;
                  3'd1: tmp = OP_MULH;
                  3'd2: tmp = OP_MULHSU;
                  3'd3: tmp = OP_MULHU;
                  3'd4: tmp = OP_DIV;
                  3'd5: tmp = OP_DIVU;
                  3'd6: tmp = OP_REM;
                  default: tmp = OP_REMU;
                endcase
              end
              default: tmp = OP_ILLEGAL;
            endcase
            if (tmp != OP_ILLEGAL) dec = mk(tmp, IMM_ZERO, 1'b1, 1'b1, 1'b1);
          end
          OPC_AMO: begin
            if (funct3 == 3'b010) begin
              case (funct5)
                5'b00000: tmp = OP_AADD;
                5'b00001: tmp = OP_ASWAP;
                5'b00010: tmp = rs2Zero ? OP_LRES : OP_ILLEGAL;
                5'b00011: tmp = OP_SCOND;
                5'b00100: tmp = OP_AXOR;
                5'b01000: tmp = OP_AOR;
                5'b01100: tmp = OP_AAND;
                5'b10000: tmp = OP_AMIN;
                5'b10100: tmp = OP_AMAX;
                5'b11000: tmp = OP_AMINU;
                5'b11100: tmp = OP_AMAXU;
                default:  tmp = OP_ILLEGAL;
              endcase
            end
            if (tmp == OP_LRES)         dec = mk(tmp, IMM_ZERO, 1'b1, 1'b0, 1'b1);
            else if (tmp != OP_ILLEGAL) dec = mk(tmp, IMM_ZERO, 1'b1, 1'b1, 1'b1);
          end
          OPC_FENCE: if (funct3 == 3'b000) dec = mk(OP_FENCE, IMM_I, 1'b0, 1'b0, 1'b0);
          OPC_SYSTEM: begin
            case (funct3)
              3'b000: begin
                if (rs1Zero && rdZero &&
                    (funct12 == 12'h000 || funct12 == 12'h001 ||
                     funct12 == 12'h302 || funct12 == 12'h105))
                  dec = mk(OP_PRIV, IMM_SYS, 1'b0, 1'b0, 1'b0);
              end
              3'b001: dec = mk(OP_CSRRW, IMM_SYS, 1'b1, 1'b0, 1'b1);
              3'b010: dec = mk(OP_CSRRS, IMM_SYS, 1'b1, 1'b0, 1'b1);
              3'b011: dec = mk(OP_CSRRC, IMM_SYS, 1'b1, 1'b0, 1'b1);
              3'b101: dec = mk(OP_CSRRWI, IMM_SYS, 1'b1, 1'b0, 1'b1);
              3'b110: dec = mk(OP_CSRRSI, IMM_SYS, 1'b1, 1'b0, 1'b1);
              3'b111: dec = mk(OP_CSRRCI, IMM_SYS, 1'b1, 1'b0, 1'b1);
              default: dec = mk(OP_ILLEGAL, IMM_ZERO, 1'b0, 1'b0, 1'b0);
            endcase
          end
          default: dec = mk(OP_ILLEGAL, IMM_ZERO, 1'b0, 1'b0, 1'b0);
        endcase
      end
    end
  end

  always_comb begin
    strobes      = dec;
    strobes.load = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/predec_datapath.sv
module predec_datapath
  import predec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [XLEN-1:7]    instHi,
  input  decStrobes_t        strobes,
  output logic [ENTRY_W-1:0] entry
);

  logic [XLEN-1:0]    immVal;
  logic [REG_W-1:0]   rs1Fld, rs2Fld, rdFld;
  logic [ENTRY_W-1:0] entryD;
  logic [OP_W-1:0]    opField;

  always_comb begin
    case (strobes.immSel)
      IMM_I:     immVal = {{20{instHi[31]}}, instHi[31:20]};
      IMM_S:     immVal = {{20{instHi[31]}}, instHi[31:25], instHi[11:7]};
      IMM_B:     immVal = {{19{instHi[31]}}, instHi[31], instHi[7], instHi[30:25],
                           instHi[11:8], 1'b0};
      IMM_U:     immVal = {instHi[31:12], 12'b0};
      IMM_J:     immVal = {{11{instHi[31]}}, instHi[31], instHi[19:12], instHi[20],
                           instHi[30:21], 1'b0};
      IMM_SYS:   immVal = {20'b0, instHi[31:20]};
      IMM_SHAMT: immVal = {27'b0, instHi[24:20]};
      default:   immVal = '0;
    endcase
  end

  assign rs1Fld = strobes.useRs1 ? instHi[19:15] : '0;
  assign rs2Fld = strobes.useRs2 ? instHi[24:20] : '0;
  assign rdFld  = strobes.useRd  ? instHi[11:7]  : '0;
  assign entryD = {strobes.opId, rs2Fld, rs1Fld, rdFld, immVal};

  always_ff @(posedge clk) begin
    if (!rstN)             entry <= '0;
    else if (strobes.load) entry <= entryD;
  end

  assign opField = entry[ENTRY_W-1:OP_LSB];

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(entry));

  // R12
  illegal_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opField == OP_ILLEGAL) |-> (entry[OP_LSB-1:0] == '0));

  // R13
  upper_regs_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opField == OP_LUI || opField == OP_AUIPC || opField == OP_JAL)
      |-> (entry[OP_LSB-1:RD_LSB+REG_W] == '0));

  // R9
  csr_addr_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opField inside {OP_CSRRW, OP_CSRRS, OP_CSRRC, OP_CSRRWI, OP_CSRRSI, OP_CSRRCI})
      |-> (entry[XLEN-1:12] == '0));

  // R10
  priv_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opField == OP_PRIV) |-> (entry[XLEN-1:0] inside {32'h0, 32'h1, 32'h302, 32'h105}));

endmodule

// File: rtl/predec_packer.sv
module predec_packer
  import predec_pkg::*;
#(
  parameter logic [6:0] CUSTOM_OPCODE = 7'b0001011
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [XLEN-1:0]    inInst,
  output logic               outValid,
  output logic [ENTRY_W-1:0] outEntry
);

  decStrobes_t strobes;

  predec_ctrl #(.CUSTOM_OPCODE(CUSTOM_OPCODE)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inst     (inInst),
    .strobes  (strobes),
    .outValid (outValid)
  );

  predec_datapath uData (
    .clk     (clk),
    .rstN    (rstN),
    .instHi  (inInst[XLEN-1:7]),
    .strobes (strobes),
    .entry   (outEntry)
  );

endmodule

// File: tb/predec_packer_test.sv
`timescale 1ns/1ps
module predec_packer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inInst = 32'h0;
  logic        outValid;
  logic [53:0] outEntry;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  predec_packer uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inInst(inInst),
    .outValid(outValid), .outEntry(outEntry)
  );

  function automatic logic [53:0] pack(int op, int rs2, int rs1, int rd, logic [31:0] imm);
    logic [6:0] o = 7'(op);
    return {o, 5'(rs2), 5'(rs1), 5'(rd), imm};
  endfunction

  function automatic logic [31:0] encR(logic [6:0] f7, int rs2, int rs1, logic [2:0] f3,
                                       int rd, logic [6:0] opc);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), opc};
  endfunction

  function automatic logic [31:0] encI(logic [31:0] imm, int rs1, logic [2:0] f3,
                                       int rd, logic [6:0] opc);
    return {imm[11:0], 5'(rs1), f3, 5'(rd), opc};
  endfunction

  function automatic logic [31:0] encS(logic [31:0] imm, int rs2, int rs1, logic [2:0] f3,
                                       logic [6:0] opc);
    return {imm[11:5], 5'(rs2), 5'(rs1), f3, imm[4:0], opc};
  endfunction

  function automatic logic [31:0] encB(logic [31:0] imm, int rs2, int rs1, logic [2:0] f3);
    return {imm[12], imm[10:5], 5'(rs2), 5'(rs1), f3, imm[4:1], imm[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] encJ(logic [31:0] imm, int rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], 5'(rd), 7'b1101111};
  endfunction

  task automatic chk(string tag, logic [53:0] act, logic [53:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive a word with valid high, then sample after the capturing edge
  task automatic send(string tag, logic [31:0] ins, logic [53:0] exp);
    inInst  = ins;
    inValid = 1'b1;
    @(negedge clk);
    chk({tag, " valid"}, 54'(outValid), 54'd1);
    chk(tag, outEntry, exp);
  endtask

  task automatic testReset();
    chk("R2 reset entry", outEntry, 54'd0);
    chk("R2 reset valid", 54'(outValid), 54'd0);
  endtask

  task automatic testBranches();
    send("R3 BEQ", encB(-8, 2, 1, 3'b000), pack(-64, 2, 1, 0, -8));
    send("R3 BGEU", encB(4094, 31, 30, 3'b111), pack(-57, 31, 30, 0, 4094));
    send("R3 BLT", encB(-4096, 4, 3, 3'b100), pack(-60, 4, 3, 0, -4096));
    send("R3 R12 bad funct3", encB(8, 1, 1, 3'b010), 54'd0);
  endtask

  task automatic testMemory();
    send("R4 LW", encI(-2048, 6, 3'b010, 5, 7'b0000011), pack(-54, 0, 6, 5, -2048));
    send("R4 LHU", encI(2047, 9, 3'b101, 10, 7'b0000011), pack(-51, 0, 9, 10, 2047));
    send("R4 SB", encS(-1, 7, 8, 3'b000, 7'b0100011), pack(-50, 7, 8, 0, -1));
    send("R4 SW", encS(100, 11, 12, 3'b010, 7'b0100011), pack(-48, 11, 12, 0, 100));
  endtask

  task automatic testUpperJump();
    send("R5 R13 LUI", {20'hABCDE, 5'd3, 7'b0110111}, pack(-53, 0, 0, 3, 32'hABCDE000));
    send("R5 AUIPC", {20'h80001, 5'd4, 7'b0010111}, pack(-8, 0, 0, 4, 32'h80001000));
    send("R5 JAL", encJ(-1048576, 1), pack(-62, 0, 0, 1, -1048576));
    send("R5 JALR", encI(12, 2, 3'b000, 1, 7'b1100111), pack(-61, 0, 2, 1, 12));
  endtask

  task automatic testOpImm();
    send("R6 ADDI", encI(-1, 0, 3'b000, 1, 7'b0010011), pack(-36, 0, 0, 1, -1));
    send("R6 SLTIU", encI(5, 2, 3'b011, 3, 7'b0010011), pack(-33, 0, 2, 3, 5));
    send("R6 SRAI", encR(7'b0100000, 31, 5, 3'b101, 4, 7'b0010011), pack(-1, 0, 5, 4, 31));
    send("R6 SLLI", encR(7'b0000000, 7, 5, 3'b001, 4, 7'b0010011), pack(-3, 0, 5, 4, 7));
    send("R6 R12 bad SLLI", encR(7'b0100000, 7, 5, 3'b001, 4, 7'b0010011), 54'd0);
  endtask

  task automatic testRegOps();
    send("R7 SUB", encR(7'b0100000, 3, 2, 3'b000, 1, 7'b0110011), pack(-35, 3, 2, 1, 0));
    send("R7 SLTU", encR(7'b0000000, 3, 2, 3'b011, 1, 7'b0110011), pack(-25, 3, 2, 1, 0));
    send("R7 XOR", encR(7'b0000000, 3, 2, 3'b100, 1, 7'b0110011), pack(-24, 3, 2, 1, 0));
    send("R7 MULHSU", encR(7'b0000001, 9, 8, 3'b010, 7, 7'b0110011), pack(-18, 9, 8, 7, 0));
    send("R7 REMU", encR(7'b0000001, 9, 8, 3'b111, 7, 7'b0110011), pack(-13, 9, 8, 7, 0));
    send("R7 R12 bad funct7", encR(7'b0000010, 9, 8, 3'b000, 7, 7'b0110011), 54'd0);
  endtask

  task automatic testAtomics();
    send("R8 AMOMAXU aqrl", encR(7'b1110011, 4, 5, 3'b010, 6, 7'b0101111), pack(-37, 4, 5, 6, 0));
    send("R8 AMOADD", encR(7'b0000000, 4, 5, 3'b010, 6, 7'b0101111), pack(-47, 4, 5, 6, 0));
    send("R8 LR", encR(7'b0001000, 0, 5, 3'b010, 6, 7'b0101111), pack(-45, 0, 5, 6, 0));
    send("R8 R12 LR rs2", encR(7'b0001000, 3, 5, 3'b010, 6, 7'b0101111), 54'd0);
    send("R8 R12 AMO width", encR(7'b0000000, 4, 5, 3'b011, 6, 7'b0101111), 54'd0);
  endtask

  task automatic testSystem();
    send("R9 CSRRW", encI(32'h300, 2, 3'b001, 1, 7'b1110011), pack(-11, 0, 2, 1, 32'h300));
    send("R9 CSRRCI", encI(32'hFFF, 17, 3'b111, 3, 7'b1110011), pack(-5, 0, 17, 3, 32'hFFF));
    send("R10 ECALL", 32'h00000073, pack(-12, 0, 0, 0, 0));
    send("R10 EBREAK", 32'h00100073, pack(-12, 0, 0, 0, 1));
    send("R10 MRET", 32'h30200073, pack(-12, 0, 0, 0, 32'h302));
    send("R10 WFI", 32'h10500073, pack(-12, 0, 0, 0, 32'h105));
    send("R10 bad code", 32'h00300073, 54'd0);
    send("R10 ECALL rd", 32'h00000173, 54'd0);
    send("R10 FENCE", 32'h0FF0000F, pack(-4, 0, 0, 0, 255));
  endtask

  task automatic testCustomAndJunk();
    send("R11 custom A", encI(5, 3, 3'b000, 2, 7'b0001011), pack(1, 0, 3, 2, 5));
    send("R11 custom B", encI(-3, 4, 3'b001, 6, 7'b0001011), pack(2, 0, 4, 6, -3));
    send("R11 R12 custom bad", encI(5, 3, 3'b010, 2, 7'b0001011), 54'd0);
    send("R12 low bits", 32'h00000001, 54'd0);
    send("R12 zero word", 32'h00000000, 54'd0);
  endtask

  task automatic testHold();
    send("R1 before gap", encI(7, 1, 3'b000, 2, 7'b0010011), pack(-36, 0, 1, 2, 7));
    inValid = 1'b0;
    inInst  = encR(7'b0000000, 3, 2, 3'b000, 1, 7'b0110011);
    @(negedge clk);
    chk("R1 valid low", 54'(outValid), 54'd0);
    chk("R1 entry held", outEntry, pack(-36, 0, 1, 2, 7));
    @(negedge clk);
    chk("R1 still held", outEntry, pack(-36, 0, 1, 2, 7));
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBranches();
    testMemory();
    testUpperJump();
    testOpImm();
    testRegOps();
    testAtomics();
    testSystem();
    testCustomAndJunk();
    testHold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule